// File: doc/BRIEF.md
# Configuration Memory Readout Sequencer

This block reads a stored configuration image out of a small on-chip memory and presents it, one word per clock, to a downstream device that is being configured. The memory holds several equal-sized images ("revisions"). While the output-enable/reset line is low, the sequencer chooses one revision and parks its address counter at the first word of that revision's region. Once the line is released and chip enable is asserted, the counter steps through the region one word per rising clock edge.

In parallel mode the consumer can stall the stream with a busy input. In serial mode that input is ignored. The revision comes either from two external select pins or from two internal control bits, chosen by an external-select flag. After the last word of the region has been consumed, the data bus is switched off and an active-low chain-enable output is pulled low. That output hands the stream on to the next sequencer in a daisy chain. The block also forwards its clock, together with an output enable that honours chip enable, output-enable/reset and a forwarding-enable bit.

Top module: `cfgseq_top`

## Requirements
- R1: While `oe_rstn` is low, or while `rst` is high at a clock edge, the counter reloads to the first address of the selected revision and the spent state is cleared. With the default sizes, revision r starts at address 16*r.
- R2: At a reload edge, the revision comes from `rev_pin` when `ext_sel` is 0 and from `rev_int` when `ext_sel` is 1. Changes to these inputs while `oe_rstn` is high have no effect on the address.
- R3: Streaming means `ce_n` is 0 and `oe_rstn` is 1. While streaming and not stalled, each rising edge advances the address by one.
- R4: When `par_mode` is 1 and `busy` is 1, the address and `dout` hold. On the first edge after `busy` falls, the word at the next address appears.
- R5: When `par_mode` is 0, `busy` has no effect and the address keeps advancing.
- R6: While `ce_n` is 1, the address holds, and both `dout_oe` and `clk_fwd_oe` are 0.
- R7: The terminal count is the last address of the region, offset 15 with the default sizes. The edge that consumes the word at the terminal count enters the spent state. In the spent state the counter stops and `dout_oe` is 0 until the next reload.
- R8: `chain_ce_n` is 0 only when `ce_n` is 0, `oe_rstn` is 1 and the spent state is set. It is 1 at once when `ce_n` goes high or `oe_rstn` goes low.
- R9: `clk_fwd_oe` is 1 exactly when streaming and `fwd_clk_en` is 1. `clk_fwd` carries `clk`.
- R10: `dout` shows the word at the current address. The word at address a is ((a*29) mod 256) XOR 0xA5, and `dout_oe` is 1 while streaming and not spent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_rstn | input | 1 | Output enable; low reloads the counter |
| busy | input | 1 | Stall request, honoured in parallel mode |
| par_mode | input | 1 | 1 = parallel readout, 0 = serial |
| ext_sel | input | 1 | 0 = revision from pins, 1 = from internal bits |
| rev_pin | input | 2 | External revision select |
| rev_int | input | 2 | Internal revision control bits |
| fwd_clk_en | input | 1 | Enable bit for the forwarded clock |
| dout | output | 8 | Configuration word |
| dout_oe | output | 1 | Output enable for `dout` |
| clk_fwd | output | 1 | Forwarded clock |
| clk_fwd_oe | output | 1 | Output enable for `clk_fwd` |
| chain_ce_n | output | 1 | Active-low enable for the next device in the chain |

## Verification
The hold property assumes that `dout` depends only on the stored address, so revision inputs never change mid-stream except through a reload. The bench keeps to this by changing `rev_pin` and `rev_int` only around reload cycles. The one exception is a deliberate change while `oe_rstn` is high, made to show that it has no effect. The serial-advance property relies on neighbouring words being different, which holds because 29 is odd. All inputs change half a cycle away from the active clock edge, so every property samples settled values.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    // Revision select width (fixed by the two-pin select interface)
    localparam int REV_W = 2;

    // Stream state of the sequencer
    typedef enum logic [1:0] {
        SQ_PARKED,   // not streaming (chip disabled or held in reload)
        SQ_STREAM,   // delivering words
        SQ_SPENT     // region exhausted, hand-off to chain
    } sq_state_e;

    // Control decisions derived from the input pins each cycle
    typedef struct packed {
        logic active;   // chip enabled and not in reload
        logic reload;   // park counter at region start
        logic stall;    // parallel-mode busy
    } sq_ctrl_t;

    // Stored word at a linear address
    function automatic logic [31:0] cfg_word(input int unsigned idx);
        return (idx * 32'd29) ^ 32'h0000_00A5;
    endfunction

endpackage

// File: rtl/cfgseq_revsel.sv
module cfgseq_revsel
    import cfgseq_pkg::*;
(
    input  logic             clk,
    input  logic             load,
    input  logic             ext_sel,
    input  logic [REV_W-1:0] rev_pin,
    input  logic [REV_W-1:0] rev_int,
    output logic [REV_W-1:0] rev_q
);

    logic [REV_W-1:0] rev_pick;

    always_comb begin
        rev_pick = ext_sel ? rev_int : rev_pin;
    end

    always_ff @(posedge clk) begin
        if (load) begin
            rev_q <= rev_pick;
        end
    end

endmodule

// File: rtl/cfgseq_offset.sv
module cfgseq_offset
    import cfgseq_pkg::*;
#(
    parameter int REGION_DEPTH = 16,
    localparam int OFF_W = $clog2(REGION_DEPTH)
) (
    input  logic             clk,
    input  logic             reload,
    input  logic             step,
    output logic [OFF_W-1:0] offset,
    output logic             spent
);

    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(REGION_DEPTH - 1);

    always_ff @(posedge clk) begin
        if (reload) begin
            offset <= '0;
            spent  <= 1'b0;
        end else if (step && !spent) begin
            if (offset == OFF_LAST) begin
                spent <= 1'b1;
            end else begin
                offset <= offset + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfgseq_rom.sv
module cfgseq_rom
    import cfgseq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [31:0] full;
        assign full     = cfg_word(i);
        assign cells[i] = full[DATA_W-1:0];
    end

    assign data = cells[addr];

endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
    import cfgseq_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int REGION_DEPTH = 16,
    localparam int REV_COUNT   = 1 << REV_W,
    localparam int DEPTH       = REV_COUNT * REGION_DEPTH,
    localparam int OFF_W       = $clog2(REGION_DEPTH),
    localparam int ADDR_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_rstn,
    input  logic              busy,
    input  logic              par_mode,
    input  logic              ext_sel,
    input  logic [REV_W-1:0]  rev_pin,
    input  logic [REV_W-1:0]  rev_int,
    input  logic              fwd_clk_en,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              clk_fwd,
    output logic              clk_fwd_oe,
    output logic              chain_ce_n
);

    sq_ctrl_t         ctl;
    sq_state_e        state;
    logic [REV_W-1:0] rev_q;
    logic [OFF_W-1:0] offset;
    logic             spent;
    logic [ADDR_W-1:0] addr;

    always_comb begin
        ctl.active = !ce_n && oe_rstn;
        ctl.reload = rst || !oe_rstn;
        ctl.stall  = par_mode && busy;
    end

    cfgseq_revsel u_revsel (
        .clk     (clk),
        .load    (ctl.reload),
        .ext_sel (ext_sel),
        .rev_pin (rev_pin),
        .rev_int (rev_int),
        .rev_q   (rev_q)
    );

    cfgseq_offset #(
        .REGION_DEPTH (REGION_DEPTH)
    ) u_offset (
        .clk    (clk),
        .reload (ctl.reload),
        .step   (ctl.active && !ctl.stall),
        .offset (offset),
        .spent  (spent)
    );

    assign addr = {rev_q, offset};

    cfgseq_rom #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_rom (
        .addr (addr),
        .data (dout)
    );

    always_comb begin
        if (!ctl.active)  state = SQ_PARKED;
        else if (spent)   state = SQ_SPENT;
        else              state = SQ_STREAM;
    end

    assign dout_oe    = (state == SQ_STREAM);
    assign chain_ce_n = (state != SQ_SPENT);
    assign clk_fwd    = clk;
    assign clk_fwd_oe = (state != SQ_PARKED) && fwd_clk_en;

endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker
    import cfgseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_rstn,
    input logic              busy,
    input logic              par_mode,
    input logic              fwd_clk_en,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe,
    input logic              clk_fwd_oe,
    input logic              chain_ce_n
);

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (oe_rstn && par_mode && busy) |=> $stable(dout));

    p_serial_moves_r5: assert property (@(posedge clk) disable iff (rst)
        (!par_mode && dout_oe) |=> (!$stable(dout) || !dout_oe));

    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (!dout_oe && !clk_fwd_oe));

    p_handoff_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !chain_ce_n |-> (!ce_n && oe_rstn));

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (ce_n || !oe_rstn) |-> chain_ce_n);

    p_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(dout_oe && !chain_ce_n));

    p_fwd_gate_r9: assert property (@(posedge clk) disable iff (rst)
        clk_fwd_oe |-> (!ce_n && oe_rstn && fwd_clk_en));

    p_reload_clears_r1: assert property (@(posedge clk) disable iff (rst)
        (!oe_rstn) |=> (chain_ce_n || !oe_rstn || ce_n) && !(!chain_ce_n));

endmodule

bind cfgseq_top cfgseq_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cfgseq_top_bench.sv
`timescale 1ns/100ps
module cfgseq_top_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       ce_n, oe_rstn, busy, par_mode, ext_sel, fwd_clk_en;
    logic [1:0] rev_pin, rev_int;
    logic [7:0] dout;
    logic       dout_oe, clk_fwd, clk_fwd_oe, chain_ce_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cfgseq_top u_cfgseq_top (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_rstn(oe_rstn), .busy(busy),
        .par_mode(par_mode), .ext_sel(ext_sel), .rev_pin(rev_pin),
        .rev_int(rev_int), .fwd_clk_en(fwd_clk_en), .dout(dout),
        .dout_oe(dout_oe), .clk_fwd(clk_fwd), .clk_fwd_oe(clk_fwd_oe),
        .chain_ce_n(chain_ce_n)
    );

    // Expected stored word, from R10
    function automatic logic [7:0] word_at(input int a);
        return 8'((a * 29) % 256) ^ 8'hA5;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    typedef struct packed {
        logic       ce_n;
        logic       oe;
        logic       busy;
        logic       par;
        logic       ext;
        logic [1:0] pin;
        logic [1:0] intl;
        logic       fwd;
        logic [5:0] addr;
        logic       doe;
        logic       chain;
        logic       fwdoe;
    } vec_t;

    localparam int NV = 11;
    // Each row: inputs applied, one clock edge, then outputs compared
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 2'd1, 1'b1, 6'd32, 1'b0, 1'b1, 1'b0}, // R1 R2 pins -> rev 2
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd1, 1'b1, 6'd33, 1'b1, 1'b1, 1'b1}, // R3
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 2'd1, 1'b1, 6'd34, 1'b1, 1'b1, 1'b1}, // R5 busy ignored
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 2'd1, 1'b1, 6'd34, 1'b1, 1'b1, 1'b1}, // R4 stall
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 2'd1, 1'b1, 6'd34, 1'b1, 1'b1, 1'b1}, // R4 stall
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1, 1'b1, 6'd35, 1'b1, 1'b1, 1'b1}, // R4 resume
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1, 1'b1, 6'd35, 1'b0, 1'b1, 1'b0}, // R6
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1, 1'b0, 6'd36, 1'b1, 1'b1, 1'b0}, // R9
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd1, 1'b1, 6'd16, 1'b0, 1'b1, 1'b0}, // R2 internal bits
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd1, 1'b1, 6'd17, 1'b1, 1'b1, 1'b1}, // R3
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 1'b1, 6'd18, 1'b1, 1'b1, 1'b1}  // R2 no effect
    };

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1; ce_n = 1'b0; oe_rstn = 1'b1; busy = 1'b0; par_mode = 1'b0;
        ext_sel = 1'b0; rev_pin = 2'd0; rev_int = 2'd0; fwd_clk_en = 1'b1;
        repeat (3) tick();
        // Reset state: revision 0, first word, not spent
        check("R1 reset dout", dout, word_at(0));
        check("R8 reset chain", chain_ce_n, 1);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ce_n = TBL[i].ce_n; oe_rstn = TBL[i].oe; busy = TBL[i].busy;
            par_mode = TBL[i].par; ext_sel = TBL[i].ext; rev_pin = TBL[i].pin;
            rev_int = TBL[i].intl; fwd_clk_en = TBL[i].fwd;
            tick();
            check($sformatf("R10 row%0d dout", i), dout, word_at(int'(TBL[i].addr)));
            check($sformatf("R6 row%0d dout_oe", i), dout_oe, TBL[i].doe);
            check($sformatf("R8 row%0d chain", i), chain_ce_n, TBL[i].chain);
            check($sformatf("R9 row%0d fwd_oe", i), clk_fwd_oe, TBL[i].fwdoe);
        end

        // Terminal count on revision 3 (addresses 48..63)
        @(negedge clk);
        oe_rstn = 1'b0; ce_n = 1'b0; ext_sel = 1'b0; rev_pin = 2'd3; busy = 1'b0; par_mode = 1'b0;
        tick();
        check("R1 reload rev3", dout, word_at(48));
        @(negedge clk);
        oe_rstn = 1'b1;
        repeat (15) tick();
        check("R7 at terminal dout", dout, word_at(63));
        check("R7 at terminal oe", dout_oe, 1);
        check("R8 at terminal chain", chain_ce_n, 1);
        tick();
        check("R7 spent oe", dout_oe, 0);
        check("R8 spent chain", chain_ce_n, 0);
        repeat (2) tick();
        check("R7 counter stopped", dout, word_at(63));
        check("R8 chain held", chain_ce_n, 0);
        @(negedge clk);
        ce_n = 1'b1;
        #1;
        check("R8 ce release", chain_ce_n, 1);
        @(negedge clk);
        ce_n = 1'b0;
        #1;
        check("R8 spent persists", chain_ce_n, 0);
        @(negedge clk);
        oe_rstn = 1'b0;
        #1;
        check("R8 oe release", chain_ce_n, 1);
        tick();
        @(negedge clk);
        oe_rstn = 1'b1;
        #1;
        check("R1 spent cleared oe", dout_oe, 1);
        check("R1 restart dout", dout, word_at(48));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule